// File: doc/BRIEF.md
# Two-Wire EEPROM Random-Read Sequencer

This block fetches one byte from a serial EEPROM that sits on a two-wire bus and uses a 16-bit word address. A single-cycle request carries the address. The sequencer first sends a dummy write to set the device's address pointer. It then issues a repeated start, addresses the device for reading and clocks in the data byte. It finishes every access with a stop condition. The result is reported either as a success pulse with the byte, or as an error pulse when the device did not acknowledge one of the bytes sent to it.

The bus is driven as an open-drain pair. `sclOut` is the clock level. `sdaOut` and `sdaOe` form the data driver: the line is pulled low only when `sdaOe` is 1 and `sdaOut` is 0. The line level comes back on `sdaIn` and passes through a synchronizer of `SYNC_STAGES` flops. All bus timing comes from a step of `STEP_DIV` clock cycles, and each step changes at most one line. The 7-bit device address is the parameter `DEV_ADDR`, whose default `7'h50` gives the bytes 0xA0 (write) and 0xA1 (read). `STEP_DIV` must be larger than `SYNC_STAGES`.

Top module: `eepromRandRead`

## Requirements
- R1: After reset and whenever `busy` is low, `sclOut` is 1, `sdaOut` is 1 and `sdaOe` is 0. After reset, `doneOk` and `nackErr` are 0 and `readData` is 0x00.
- R2: A `startReq` sampled while `busy` is low latches `readAddr` and raises `busy` in the next cycle.
- R3: A `startReq` while `busy` is high has no effect. The running access keeps its latched address, and no new access follows it.
- R4: The bus sequence is: start, byte {DEV_ADDR,0}, address bits 15:8, address bits 7:0, repeated start, byte {DEV_ADDR,1}. Every byte is sent most significant bit first. A data bit is placed while the clock is low and then clocked by one high pulse.
- R5: Each change of `sclOut`, `sdaOut` or `sdaOe` is held for at least `STEP_DIV` clock cycles before the next change.
- R6: After each transmitted byte, the master releases `sdaOe` and gives one extra clock pulse. The line is sampled at the end of that pulse, and 0 means acknowledge.
- R7: During every clock-high phase in which the device drives data (acknowledge bits and read bits), `sdaOe` is 0.
- R8: An acknowledge bit sampled as 1, at any of the four transmitted bytes, ends the access with a stop condition and a `nackErr` pulse. No further byte is sent.
- R9: The eight read bits are sampled MSB first at the end of each clock-high phase. The master drives no acknowledge after them and goes straight to the stop condition. The byte appears on `readData` in the cycle that `doneOk` pulses.
- R10: An access that ends with `nackErr` leaves `readData` unchanged.
- R11: `doneOk` and `nackErr` are single-cycle and never high together. They occur in the first cycle that `busy` is low after an access.
- R12: Every access, including an aborted one, issues exactly one stop condition (data rising while the clock is high), and this happens before `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request a read; only honoured while idle |
| readAddr | input | 16 | EEPROM word address, latched with the request |
| busy | output | 1 | Access in progress, through the end of the stop condition |
| doneOk | output | 1 | One-cycle pulse: byte read successfully |
| nackErr | output | 1 | One-cycle pulse: a missing acknowledge aborted the access |
| readData | output | 8 | Last byte read successfully |
| sclOut | output | 1 | Bus clock level |
| sdaOut | output | 1 | Data level driven when enabled |
| sdaOe | output | 1 | Data driver enable |
| sdaIn | input | 1 | Sensed data line level |

## Verification
The bench builds the block with `STEP_DIV` set to 5 and `SYNC_STAGES` at its default of 2. This keeps a complete read to about 700 cycles, so a dozen accesses fit easily in one run. That includes a missing acknowledge at each of the four transmitted bytes, the all-zero and all-one addresses, and a request made in the middle of an access. A step of five cycles still leaves three cycles of margin after the two-flop synchronizer. This margin exercises the rule that the device changes the line at the clock's falling edge and the master samples it a full step later.

// File: rtl/eeRdPkg.sv
package eeRdPkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  // which byte is loaded into the transmit shifter
  typedef enum logic [1:0] {
    SEL_DEVW = 2'd0,
    SEL_ADRH = 2'd1,
    SEL_ADRL = 2'd2,
    SEL_DEVR = 2'd3
  } byteSel_e;

  // one bus step per phase; every phase changes at most one line
  typedef enum logic [4:0] {
    PH_IDLE,
    PH_S1,    // release data high, enable driver
    PH_S2,    // clock high
    PH_S3,    // data low while clock high: start
    PH_S4,    // clock low
    PH_TXD,   // place bit while clock low
    PH_TXH,   // clock high
    PH_TXL,   // clock low
    PH_ACKR,  // release driver
    PH_ACKH,  // clock high, sample acknowledge
    PH_ACKL,  // clock low
    PH_RXH,   // clock high, sample read bit
    PH_RXL,   // clock low
    PH_PA,    // drive data low while clock low
    PH_PB,    // clock high
    PH_PC,    // data high while clock high: stop
    PH_PD     // release driver, report
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     adv;        // a new step begins at this edge
    logic     wrScl;
    logic     sclLvl;
    logic     wrSda;
    logic     sdaLvl;
    logic     wrOe;
    logic     oeLvl;
    logic     txFirst;    // load shifter, drive its MSB
    logic     txNext;     // drive next bit
    byteSel_e byteSel;
    logic     latchAddr;
    logic     sampleRx;
    logic     publish;
  } dpCmd_t;

endpackage

// File: rtl/eeRdDatapath.sv
module eeRdDatapath
  import eeRdPkg::*;
#(
  parameter int STEP_DIV = 50,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  logic                busy,
  input  logic [ADDR_W-1:0]   readAddr,
  input  logic                sdaIn,
  output logic                stepDone,
  output logic                sdaSync,
  output logic                sclOut,
  output logic                sdaOut,
  output logic                sdaOe,
  output logic [BYTE_W-1:0]   readData
);

  localparam int CNT_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_DIV - 1);

  logic [CNT_W-1:0]  stepCnt;
  logic [ADDR_W-1:0] addrHold;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] selByte;

  // step timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
    end else if (cmd.adv) begin
      stepCnt <= '0;
    end else if (busy) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  assign stepDone = busy && (stepCnt == CNT_LAST);

  // input synchronizer, depth picked by parameter
  generate
    if (SYNC_STAGES <= 1) begin : gSync1
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= sdaIn;
      end
      assign sdaSync = syncQ;
    end else begin : gSyncN
      logic [SYNC_STAGES-1:0] syncChain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], sdaIn};
      end
      assign sdaSync = syncChain[SYNC_STAGES-1];
    end
  endgenerate

  // byte selection
  always_comb begin
    case (cmd.byteSel)
      SEL_DEVW: selByte = {DEV_ADDR, 1'b0};
      SEL_ADRH: selByte = addrHold[ADDR_W-1:BYTE_W];
      SEL_ADRL: selByte = addrHold[BYTE_W-1:0];
      default:  selByte = {DEV_ADDR, 1'b1};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold <= '0;
    end else if (cmd.latchAddr) begin
      addrHold <= readAddr;
    end
  end

  // transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (cmd.txFirst) begin
      txShift <= {selByte[BYTE_W-2:0], 1'b0};
    end else if (cmd.txNext) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  // receive shifter and result register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      readData <= '0;
    end else begin
      if (cmd.sampleRx) rxShift <= {rxShift[BYTE_W-2:0], sdaSync};
      if (cmd.publish)  readData <= rxShift;
    end
  end

  // bus line registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOut <= 1'b1;
      sdaOut <= 1'b1;
      sdaOe  <= 1'b0;
    end else begin
      if (cmd.wrScl) sclOut <= cmd.sclLvl;
      if (cmd.txFirst)      sdaOut <= selByte[BYTE_W-1];
      else if (cmd.txNext)  sdaOut <= txShift[BYTE_W-1];
      else if (cmd.wrSda)   sdaOut <= cmd.sdaLvl;
      if (cmd.wrOe) sdaOe <= cmd.oeLvl;
    end
  end

endmodule

// File: rtl/eeRdControl.sv
module eeRdControl
  import eeRdPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   stepDone,
  input  logic   sdaSync,
  output dpCmd_t cmd,
  output logic   busy,
  output logic   doneOk,
  output logic   nackErr
);

  localparam logic [2:0] BIT_TOP  = 3'd7;
  localparam logic [1:0] IDX_LO   = 2'd2;
  localparam logic [1:0] IDX_DEVR = 2'd3;

  phase_e     ph, nextPh;
  logic [2:0] bitCnt, bitCntNx;
  logic [1:0] byteIdx, byteIdxNx;
  logic       nackSeen, nackNx;
  logic       doneNx, errNx;
  logic       adv, txFirst, txNext, sampleRx, latchAddr, publish;

  assign busy = (ph != PH_IDLE);

  // sequencing
  always_comb begin
    nextPh    = ph;
    bitCntNx  = bitCnt;
    byteIdxNx = byteIdx;
    nackNx    = nackSeen;
    adv       = 1'b0;
    txFirst   = 1'b0;
    txNext    = 1'b0;
    sampleRx  = 1'b0;
    latchAddr = 1'b0;
    publish   = 1'b0;
    doneNx    = 1'b0;
    errNx     = 1'b0;
    if (ph == PH_IDLE) begin
      if (startReq) begin
        adv       = 1'b1;
        nextPh    = PH_S1;
        byteIdxNx = '0;
        nackNx    = 1'b0;
        latchAddr = 1'b1;
      end
    end else if (stepDone) begin
      adv = 1'b1;
      case (ph)
        PH_S1: nextPh = PH_S2;
        PH_S2: nextPh = PH_S3;
        PH_S3: nextPh = PH_S4;
        PH_S4: begin
          nextPh   = PH_TXD;
          bitCntNx = BIT_TOP;
          txFirst  = 1'b1;
        end
        PH_TXD: nextPh = PH_TXH;
        PH_TXH: nextPh = PH_TXL;
        PH_TXL: begin
          if (bitCnt == '0) begin
            nextPh = PH_ACKR;
          end else begin
            nextPh   = PH_TXD;
            bitCntNx = bitCnt - 1'b1;
            txNext   = 1'b1;
          end
        end
        PH_ACKR: nextPh = PH_ACKH;
        PH_ACKH: begin
          nextPh = PH_ACKL;
          nackNx = sdaSync;
        end
        PH_ACKL: begin
          if (nackSeen) begin
            nextPh = PH_PA;
          end else if (byteIdx == IDX_LO) begin
            nextPh    = PH_S1;
            byteIdxNx = IDX_DEVR;
          end else if (byteIdx == IDX_DEVR) begin
            nextPh   = PH_RXH;
            bitCntNx = BIT_TOP;
          end else begin
            nextPh    = PH_TXD;
            byteIdxNx = byteIdx + 1'b1;
            bitCntNx  = BIT_TOP;
            txFirst   = 1'b1;
          end
        end
        PH_RXH: begin
          nextPh   = PH_RXL;
          sampleRx = 1'b1;
        end
        PH_RXL: begin
          if (bitCnt == '0) begin
            nextPh = PH_PA;
          end else begin
            nextPh   = PH_RXH;
            bitCntNx = bitCnt - 1'b1;
          end
        end
        PH_PA: nextPh = PH_PB;
        PH_PB: nextPh = PH_PC;
        PH_PC: nextPh = PH_PD;
        PH_PD: begin
          nextPh  = PH_IDLE;
          doneNx  = !nackSeen;
          errNx   = nackSeen;
          publish = !nackSeen;
        end
        default: nextPh = PH_IDLE;
      endcase
    end
  end

  // line strobes for the step being entered
  always_comb begin
    cmd           = '0;
    cmd.adv       = adv;
    cmd.txFirst   = txFirst;
    cmd.txNext    = txNext;
    cmd.byteSel   = byteSel_e'(byteIdxNx);
    cmd.latchAddr = latchAddr;
    cmd.sampleRx  = sampleRx;
    cmd.publish   = publish;
    if (adv) begin
      case (nextPh)
        PH_S1:   begin cmd.wrSda = 1'b1; cmd.sdaLvl = 1'b1; cmd.wrOe = 1'b1; cmd.oeLvl = 1'b1; end
        PH_S2, PH_TXH, PH_ACKH, PH_RXH, PH_PB:
                 begin cmd.wrScl = 1'b1; cmd.sclLvl = 1'b1; end
        PH_S4, PH_TXL, PH_ACKL, PH_RXL:
                 begin cmd.wrScl = 1'b1; cmd.sclLvl = 1'b0; end
        PH_S3:   begin cmd.wrSda = 1'b1; cmd.sdaLvl = 1'b0; end
        PH_TXD:  begin cmd.wrOe = 1'b1; cmd.oeLvl = 1'b1; end
        PH_ACKR: begin cmd.wrOe = 1'b1; cmd.oeLvl = 1'b0; cmd.wrSda = 1'b1; cmd.sdaLvl = 1'b1; end
        PH_PA:   begin cmd.wrSda = 1'b1; cmd.sdaLvl = 1'b0; cmd.wrOe = 1'b1; cmd.oeLvl = 1'b1; end
        PH_PC:   begin cmd.wrSda = 1'b1; cmd.sdaLvl = 1'b1; end
        PH_PD:   begin cmd.wrOe = 1'b1; cmd.oeLvl = 1'b0; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph       <= PH_IDLE;
      bitCnt   <= '0;
      byteIdx  <= '0;
      nackSeen <= 1'b0;
      doneOk   <= 1'b0;
      nackErr  <= 1'b0;
    end else begin
      ph       <= nextPh;
      bitCnt   <= bitCntNx;
      byteIdx  <= byteIdxNx;
      nackSeen <= nackNx;
      doneOk   <= doneNx;
      nackErr  <= errNx;
    end
  end

endmodule

// File: rtl/eepromRandRead.sv
module eepromRandRead
  import eeRdPkg::*;
#(
  parameter int STEP_DIV = 50,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [15:0] readAddr,
  output logic        busy,
  output logic        doneOk,
  output logic        nackErr,
  output logic [7:0]  readData,
  output logic        sclOut,
  output logic        sdaOut,
  output logic        sdaOe,
  input  logic        sdaIn
);

  dpCmd_t cmd;
  logic   stepDone;
  logic   sdaSync;

  eeRdControl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .stepDone (stepDone),
    .sdaSync  (sdaSync),
    .cmd      (cmd),
    .busy     (busy),
    .doneOk   (doneOk),
    .nackErr  (nackErr)
  );

  eeRdDatapath #(
    .STEP_DIV    (STEP_DIV),
    .SYNC_STAGES (SYNC_STAGES),
    .DEV_ADDR    (DEV_ADDR)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .busy     (busy),
    .readAddr (readAddr),
    .sdaIn    (sdaIn),
    .stepDone (stepDone),
    .sdaSync  (sdaSync),
    .sclOut   (sclOut),
    .sdaOut   (sdaOut),
    .sdaOe    (sdaOe),
    .readData (readData)
  );

endmodule

// File: rtl/eeRdChecker.sv
module eeRdChecker #(
  parameter int STEP_DIV = 50
) (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic       busy,
  input logic       doneOk,
  input logic       nackErr,
  input logic [7:0] readData,
  input logic       sclOut,
  input logic       sdaOut,
  input logic       sdaOe
);

  localparam int CW = $clog2(STEP_DIV + 1) + 1;
  localparam logic [CW-1:0] HOLD_MIN = CW'(STEP_DIV);

  logic [2:0]    linesPrev;
  logic [CW-1:0] sinceCnt;
  logic          chg;

  assign chg = ({sclOut, sdaOut, sdaOe} != linesPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linesPrev <= 3'b110;
      sinceCnt  <= HOLD_MIN;
    end else begin
      linesPrev <= {sclOut, sdaOut, sdaOe};
      if (chg)                   sinceCnt <= CW'(1);
      else if (sinceCnt < HOLD_MIN) sinceCnt <= sinceCnt + 1'b1;
    end
  end

  // R1: idle bus levels
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclOut && sdaOut && !sdaOe));

  // R2: request while idle is taken
  a_r2_start_taken: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy);

  // R5: minimum hold per line change
  a_r5_step_hold: assert property (@(posedge clk) disable iff (!rstN)
    chg |-> (sinceCnt >= HOLD_MIN));

  // R11: report pulses end the access
  a_r11_end_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (doneOk || nackErr) |-> (!busy && $past(busy)));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOk && nackErr));

  // R10: failed access keeps the result
  a_r10_hold_on_err: assert property (@(posedge clk) disable iff (!rstN)
    nackErr |-> $stable(readData));

  // R9: result changes only with success
  a_r9_data_on_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(readData) |-> doneOk);

endmodule

bind eepromRandRead eeRdChecker #(.STEP_DIV(STEP_DIV)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .busy     (busy),
  .doneOk   (doneOk),
  .nackErr  (nackErr),
  .readData (readData),
  .sclOut   (sclOut),
  .sdaOut   (sdaOut),
  .sdaOe    (sdaOe)
);

// File: tb/tb_eepromRandRead.sv
module tb_eepromRandRead;

  localparam int STEP = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [15:0] readAddr = '0;
  logic        busy, doneOk, nackErr, sclOut, sdaOut, sdaOe;
  logic [7:0]  readData;

  logic driveLow = 1'b0;
  wire  sdaLine = !((sdaOe && !sdaOut) || driveLow);

  always #10 clk = ~clk;

  eepromRandRead #(.STEP_DIV(STEP), .SYNC_STAGES(2), .DEV_ADDR(7'h50)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .readAddr(readAddr),
    .busy(busy), .doneOk(doneOk), .nackErr(nackErr), .readData(readData),
    .sclOut(sclOut), .sdaOut(sdaOut), .sdaOe(sdaOe), .sdaIn(sdaLine)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[15:8] ^ {a[6:0], a[7]} ^ 8'h3C;
  endfunction

  // ---------------- EEPROM model ----------------
  int nackAt = -1;
  int startCnt = 0, stopCnt = 0;
  int mMode = 0;       // 0 idle, 1 receive, 2 send
  int bitN = 0, pos = 0, logCnt = 0;
  bit ackPhase = 0, gotLo = 0;
  logic [7:0] shiftIn, sendByte;
  logic [7:0] rxLog [4];

  always @(negedge sdaLine) if (sclOut === 1'b1) begin
    startCnt++;
    pos = gotLo ? 3 : 0;
    mMode = 1; bitN = 0; ackPhase = 0; driveLow = 0;
  end

  always @(posedge sdaLine) if (sclOut === 1'b1) begin
    stopCnt++;
    mMode = 0; driveLow = 0; gotLo = 0; ackPhase = 0;
  end

  always @(posedge sclOut) begin
    if (mMode == 1 && !ackPhase && bitN < 8) begin
      shiftIn = {shiftIn[6:0], sdaLine};  // R4: MSB first
      bitN++;
    end else if (mMode == 2) begin
      bitN++;
    end
  end

  always @(negedge sclOut) begin
    if (mMode == 1) begin
      if (ackPhase) begin
        ackPhase = 0; driveLow = 0;
        if (pos == nackAt) mMode = 0;
        else if (pos == 3) begin
          mMode = 2; bitN = 0;
          sendByte = memByte({rxLog[1], rxLog[2]});
          driveLow = !sendByte[7];
        end else begin
          if (pos == 2) gotLo = 1;
          pos++; bitN = 0;
        end
      end else if (bitN == 8) begin
        rxLog[pos] = shiftIn;
        logCnt = pos + 1;
        ackPhase = 1;
        driveLow = (pos != nackAt);   // R6: acknowledge is a low level
      end
    end else if (mMode == 2) begin
      if (bitN < 8) driveLow = !sendByte[7 - bitN];
      else begin driveLow = 0; mMode = 0; end
    end
  end

  // ---------------- bus monitors ----------------
  int sinceChg = 1000;
  int minHold = 1000;
  int contention = 0;
  logic [2:0] prevLines = 3'b110;

  always @(negedge clk) if (rstN) begin
    if ({sclOut, sdaOut, sdaOe} != prevLines) begin
      if (sinceChg < minHold) minHold = sinceChg;
      sinceChg = 1;
    end else if (sinceChg < 1000) sinceChg++;
    prevLines = {sclOut, sdaOut, sdaOe};
    if (sclOut && driveLow && sdaOe) contention++;  // R7
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit isErr; logic [7:0] data; } exp_t;
  exp_t expQ[$];
  logic [7:0] lastGood = 8'h00;

  always @(negedge clk) if (rstN && (doneOk || nackErr)) begin
    exp_t e;
    if (expQ.size() == 0) begin
      chk(0, "R11", "unexpected report pulse", 1, 0);
    end else begin
      e = expQ.pop_front();
      chk(nackErr == e.isErr, "R8", "nackErr", nackErr, e.isErr);
      chk(doneOk == !e.isErr, "R11", "doneOk", doneOk, !e.isErr);
      chk(!(doneOk && nackErr), "R11", "both pulses", 1, 0);
      chk(readData == e.data, e.isErr ? "R10" : "R9", "readData", readData, e.data);
      chk(stopCnt == 1, "R12", "stop before report", stopCnt, 1);
    end
  end

  // ---------------- driver ----------------
  task automatic doRead(input logic [15:0] a, input int nk, input bit poke);
    exp_t e;
    int guard;
    int startsSeen;
    logic [7:0] expLog [4];
    expLog[0] = 8'hA0; expLog[1] = a[15:8]; expLog[2] = a[7:0]; expLog[3] = 8'hA1;
    nackAt = nk; startCnt = 0; stopCnt = 0; logCnt = 0;
    e.isErr = (nk >= 0);
    e.data  = (nk >= 0) ? lastGood : memByte(a);
    if (nk < 0) lastGood = memByte(a);
    expQ.push_back(e);
    @(negedge clk);
    readAddr = a; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy == 1'b1, "R2", "busy after request", busy, 1);
    if (poke) begin
      repeat (200) @(negedge clk);
      readAddr = ~a; startReq = 1'b1;   // R3: request while busy
      @(negedge clk);
      startReq = 1'b0;
    end
    guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    chk(stopCnt == 1, "R12", "stop count", stopCnt, 1);
    chk(startCnt == ((nk < 0 || nk == 3) ? 2 : 1), "R4", "start count", startCnt,
        (nk < 0 || nk == 3) ? 2 : 1);
    chk(logCnt == ((nk < 0) ? 4 : nk + 1), "R8", "bytes sent", logCnt, (nk < 0) ? 4 : nk + 1);
    for (int i = 0; i < 4; i++) begin
      if (i < logCnt) chk(rxLog[i] == expLog[i], "R4", "byte on bus", rxLog[i], expLog[i]);
    end
    if (poke) begin
      startsSeen = startCnt;
      repeat (60) @(negedge clk);
      chk(busy == 1'b0, "R3", "no access after ignored request", busy, 0);
      chk(startCnt == startsSeen, "R3", "no extra start", startCnt, startsSeen);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // ---------------- sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sclOut == 1'b1, "R1", "scl at reset", sclOut, 1);
    chk(sdaOe == 1'b0, "R1", "oe at reset", sdaOe, 0);
    chk(sdaOut == 1'b1, "R1", "sda at reset", sdaOut, 1);
    chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
    chk(readData == 8'h00, "R1", "data at reset", readData, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!doneOk && !nackErr, "R1", "no pulse after reset", doneOk | nackErr, 0);

    doRead(16'h1234, -1, 0);
    doRead(16'h0000, -1, 0);
    doRead(16'hFFFF, -1, 0);
    doRead(16'hA55A, 0, 0);   // R8: no ack on device write byte
    doRead(16'h8001, -1, 0);
    doRead(16'h3C96, 1, 0);   // R8: no ack on high address byte
    doRead(16'h7E81, 2, 0);   // R8: no ack on low address byte
    doRead(16'h0F0F, 3, 0);   // R8: no ack on device read byte
    doRead(16'h5A01, -1, 0);  // recovery after abort
    doRead(16'h2468, -1, 1);  // R3: request during access

    chk(minHold >= STEP, "R5", "minimum line hold", minHold, STEP);
    chk(contention == 0, "R7", "driver on while device drives", contention, 0);
    chk(expQ.size() == 0, "R11", "reports outstanding", expQ.size(), 0);
    chk(sclOut && !sdaOe, "R1", "idle lines at end", {sclOut, sdaOe}, 2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule